// File: doc/BRIEF.md
# Dual-Bus CAN Repeater Logic Unit

This block is the digital core that joins one CAN protocol controller to two CAN bus segments. It also has a pair of expansion pins, so that several units can be chained into a wider bus. A dominant level from the controller, from the expansion transmit pin, or from either bus is forwarded to the buses and to the receive lines. No source has priority over another. As long as both buses are enabled, every node on either segment sees one logical bus.

All interface levels are active-low: 0 is dominant and 1 is recessive. Each of the four dominant sources passes through its own time-out timer, so that a stuck-dominant source cannot block the buses. A feedback mask stops the two buses from holding each other dominant. The mask blanks reception on a bus while this unit drives that bus, and for a short, fixed interval after the drive ends. Thermal shutdown and a debounced short-to-battery flag can switch off the drivers without stopping reception. The analog drivers, comparators and sensors sit outside the block and appear as plain digital signals. Pull-ups on the pins, which make undriven inputs read recessive or disabled, are also outside the block.

Drive requests are registered, so they follow their cause by one clock edge. The receive lines are combinational from the current inputs and the timer and mask state.

Top module: `can_dual_link`

## Requirements
- R1: After reset is released with every input recessive (all active-low inputs 1, flags 0), drv_a_n, drv_b_n, rxd_n and rxe_n are all 1.
- R2: A dominant level on tx_loc_n or tx_exp_n makes drv_a_n and drv_b_n 0 from the next clock edge. This applies to each bus whose enable is 0 and which is not blocked by a fault.
- R3: A dominant level received on an enabled, unmasked bus pulls rxd_n and rxe_n to 0 in the same cycle. From the next edge it drives the other bus (a received on A drives B, a received on B drives A).
- R4: tx_loc_n at 0 pulls both rxd_n and rxe_n to 0 whatever the enables are. tx_exp_n at 0 pulls only rxd_n to 0.
- R5: While en_a_n (en_b_n) is 1, the matching driver output stays 1 and that bus's comparator input has no effect on any output.
- R6: Reception on a bus is masked while this unit drives that bus dominant, and for FB_RELEASE_CYC clock edges after the drive ends. A masked bus neither reaches the receive lines nor drives the other bus.
- R7: When a timer input has been dominant at TIMEOUT_CYC consecutive clock edges, the timer output turns recessive and stays recessive while the input stays dominant. There are four timers: local transmit, expansion transmit, bus A receive and bus B receive.
- R8: A timer input that is recessive at one clock edge re-arms the timer. The next dominant level passes through at once and counts again from zero.
- R9: While therm_sd is 1, both driver outputs are 1. Routing to rxd_n and rxe_n is unchanged.
- R10: When sbat_a (sbat_b) has been 1 at SBAT_DEBOUNCE_CYC consecutive edges, only that bus's driver output is forced to 1. The other bus and that bus's receiver keep working. The block clears at the first edge where the flag reads 0.
- R11: While rst_n is 0, rxd_n and rxe_n are 1, the driver outputs are 1 from the first clock edge, and all timers and counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tx_loc_n | input | 1 | Local controller transmit, 0 = dominant |
| tx_exp_n | input | 1 | Expansion transmit from a chained unit, 0 = dominant |
| rxc_a_n | input | 1 | Bus A comparator result, 0 = dominant |
| rxc_b_n | input | 1 | Bus B comparator result, 0 = dominant |
| en_a_n | input | 1 | Bus A enable, 0 = enabled |
| en_b_n | input | 1 | Bus B enable, 0 = enabled |
| therm_sd | input | 1 | Thermal shutdown, 1 = drivers off |
| sbat_a | input | 1 | Bus A short-to-battery detector, 1 = short seen |
| sbat_b | input | 1 | Bus B short-to-battery detector, 1 = short seen |
| drv_a_n | output | 1 | Bus A drive request, 0 = drive dominant |
| drv_b_n | output | 1 | Bus B drive request, 0 = drive dominant |
| rxd_n | output | 1 | Receive line to the local controller |
| rxe_n | output | 1 | Receive line to chained units |

## Verification
A mask counter that is wrong shows up within FB_RELEASE_CYC edges of a drive ending. rxd_n either goes low too early while a far node is already dominant, or stays high too long. A missing mask latches both drivers dominant one edge later. A time-out counter that is wrong moves the rising edge of rxd_n away from exactly TIMEOUT_CYC edges, or fails to release it again after one recessive edge. A wrong routing term appears on the drive outputs one edge after the inputs change, and on the receive lines in the same cycle.

// File: rtl/can_link_pkg.sv
// Package: shared channel numbering for the dual-bus repeater logic.
// Assumes exactly two bus segments and four time-out channels.
package can_link_pkg;
    localparam int NBUS = 2;
    localparam int NCH  = 4;

    // Timer channel order: local transmit, expansion transmit, bus A, bus B.
    typedef enum logic [1:0] {
        CH_LOC   = 2'd0,
        CH_EXP   = 2'd1,
        CH_BUS_A = 2'd2,
        CH_BUS_B = 2'd3
    } tmr_ch_e;
endpackage

// File: rtl/dom_timeout.sv
// Module: dominant time-out filter for one active-low line.
// Passes the input through until it has been dominant at LIMIT consecutive
// clock edges, then forces recessive until the input reads recessive at an edge.
// Assumes LIMIT >= 1.
module dom_timeout #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_n,
    output logic q_n
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;
    logic         expired;

    assign expired = (cnt == W'(LIMIT));

    // Count dominant edges, saturate at the limit, clear on recessive.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (d_n)      cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign q_n = d_n | expired;

    // R7: once cut, output stays recessive while input stays dominant
    a_r7_stays_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_n && !$past(d_n) && $past(q_n)) |-> q_n);

    // R8: one recessive edge re-arms, a fresh dominant passes through
    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(d_n) && !d_n) |-> !q_n);
endmodule

// File: rtl/fb_mask.sv
// Module: feedback-suppression mask for one bus.
// Mask is active while this unit drives the bus and for REL edges after.
// Assumes REL >= 1.
module fb_mask #(
    parameter int REL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_dom,
    output logic mask
);
    localparam int W = $clog2(REL + 1);

    logic [W-1:0] hold;

    // Reload while driving, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold <= '0;
        else if (drive_dom)  hold <= W'(REL);
        else if (hold != '0) hold <= hold - 1'b1;
    end

    assign mask = drive_dom | (hold != '0);

    // R6: the end of a drive never unmasks in the same cycle
    a_r6_hold_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_dom) |-> mask);
endmodule

// File: rtl/sbat_filter.sv
// Module: debounce for one short-to-battery flag.
// off rises after DEB consecutive edges with the flag set and clears at the
// first edge where the flag reads low. Assumes DEB >= 1.
module sbat_filter #(
    parameter int DEB = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic off
);
    localparam int W = $clog2(DEB + 1);

    logic [W-1:0] cnt;

    assign off = (cnt == W'(DEB));

    // Count consecutive flagged edges, saturating at DEB.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (!flag) cnt <= '0;
        else if (!off)  cnt <= cnt + 1'b1;
    end

    // R10: a driver is only cut after the flag was seen set
    a_r10_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> $past(flag));
endmodule

// File: rtl/can_dual_link.sv
// Module: dual-bus CAN repeater logic unit (top).
// Routes dominant levels between the controller, the expansion pins and two
// buses with no priority. All levels are active-low (0 = dominant). Drive
// requests are registered; receive lines are combinational.
// Assumes the comparator inputs are already synchronous to clk.
module can_dual_link
    import can_link_pkg::*;
#(
    parameter int TIMEOUT_CYC       = 4096,
    parameter int FB_RELEASE_CYC    = 4,
    parameter int SBAT_DEBOUNCE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_loc_n,
    input  logic tx_exp_n,
    input  logic rxc_a_n,
    input  logic rxc_b_n,
    input  logic en_a_n,
    input  logic en_b_n,
    input  logic therm_sd,
    input  logic sbat_a,
    input  logic sbat_b,
    output logic drv_a_n,
    output logic drv_b_n,
    output logic rxd_n,
    output logic rxe_n
);
    logic [NBUS-1:0] en, cmp_dom, sbat, sb_off, mask, drv_q, want, out_dom;
    logic [NCH-1:0]  tin_n, tout_n;
    logic            tl, te, ra, rb;

    assign en      = {~en_b_n, ~en_a_n};
    assign cmp_dom = {~rxc_b_n, ~rxc_a_n};
    assign sbat    = {sbat_b, sbat_a};

    // Timer inputs: transmit lines as-is, receivers gated by enable and mask.
    assign tin_n[int'(CH_LOC)]   = tx_loc_n;
    assign tin_n[int'(CH_EXP)]   = tx_exp_n;
    assign tin_n[int'(CH_BUS_A)] = ~(en[0] & cmp_dom[0] & ~mask[0]);
    assign tin_n[int'(CH_BUS_B)] = ~(en[1] & cmp_dom[1] & ~mask[1]);

    for (genvar c = 0; c < NCH; c++) begin : g_tmr
        dom_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .d_n  (tin_n[c]),
            .q_n  (tout_n[c])
        );
    end

    assign tl = ~tout_n[int'(CH_LOC)];
    assign te = ~tout_n[int'(CH_EXP)];
    assign ra = ~tout_n[int'(CH_BUS_A)];
    assign rb = ~tout_n[int'(CH_BUS_B)];

    // Routing: each bus takes both transmit lines and the opposite bus.
    assign want[0] = en[0] & (tl | te | rb);
    assign want[1] = en[1] & (tl | te | ra);

    // Register the drive requests, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= want;
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        sbat_filter #(.DEB(SBAT_DEBOUNCE_CYC)) u_sb (
            .clk  (clk),
            .rst_n(rst_n),
            .flag (sbat[b]),
            .off  (sb_off[b])
        );

        assign out_dom[b] = drv_q[b] & ~therm_sd & ~sb_off[b];

        fb_mask #(.REL(FB_RELEASE_CYC)) u_fb (
            .clk      (clk),
            .rst_n    (rst_n),
            .drive_dom(out_dom[b]),
            .mask     (mask[b])
        );
    end

    assign drv_a_n = ~out_dom[0];
    assign drv_b_n = ~out_dom[1];

    // Receive lines: expansion output leaves out the expansion transmit input.
    assign rxd_n = ~rst_n | ~(tl | te | ra | rb);
    assign rxe_n = ~rst_n | ~(tl | ra | rb);

    // R5: a bus disabled at the previous edge is not driven
    a_r5_dis_a: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_a_n) |-> drv_a_n);
    a_r5_dis_b: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_b_n) |-> drv_b_n);

    // R9: thermal shutdown keeps both drivers recessive
    a_r9_therm: assert property (@(posedge clk) disable iff (!rst_n)
        therm_sd |-> (drv_a_n && drv_b_n));

    // R11: reset holds the receive lines high and clears the drivers
    a_r11_por_rx: assert property (@(posedge clk)
        !rst_n |-> (rxd_n && rxe_n));
    a_r11_por_drv: assert property (@(posedge clk)
        !rst_n |=> (drv_a_n && drv_b_n));
endmodule

// File: tb/sim_can_dual_link.sv
`timescale 1ns/1ps
module sim_can_dual_link;
    localparam int TO  = 40;
    localparam int REL = 4;
    localparam int DEB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_loc_n = 1'b1, tx_exp_n = 1'b1;
    logic ext_a_n = 1'b1, ext_b_n = 1'b1;
    logic en_a_n = 1'b0, en_b_n = 1'b0;
    logic therm_sd = 1'b0, sbat_a = 1'b0, sbat_b = 1'b0;
    logic drv_a_n, drv_b_n, rxd_n, rxe_n;
    logic rxc_a_n, rxc_b_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Wired-AND bus model: a bus is dominant if this unit or another node drives it.
    assign rxc_a_n = drv_a_n & ext_a_n;
    assign rxc_b_n = drv_b_n & ext_b_n;

    can_dual_link #(
        .TIMEOUT_CYC(TO), .FB_RELEASE_CYC(REL), .SBAT_DEBOUNCE_CYC(DEB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tx_loc_n(tx_loc_n), .tx_exp_n(tx_exp_n),
        .rxc_a_n(rxc_a_n), .rxc_b_n(rxc_b_n), .en_a_n(en_a_n), .en_b_n(en_b_n),
        .therm_sd(therm_sd), .sbat_a(sbat_a), .sbat_b(sbat_b),
        .drv_a_n(drv_a_n), .drv_b_n(drv_b_n), .rxd_n(rxd_n), .rxe_n(rxe_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic idle();
        tx_loc_n = 1'b1; tx_exp_n = 1'b1; ext_a_n = 1'b1; ext_b_n = 1'b1;
        en_a_n = 1'b0; en_b_n = 1'b0; therm_sd = 1'b0; sbat_a = 1'b0; sbat_b = 1'b0;
        tick(REL + 4);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset with a dominant transmit request
        @(negedge clk);
        tx_loc_n = 1'b0;
        tick(2);
        check("R11 rxd_n in reset", rxd_n, 1'b1);
        check("R11 rxe_n in reset", rxe_n, 1'b1);
        check("R11 drv_a_n in reset", drv_a_n, 1'b1);
        check("R11 drv_b_n in reset", drv_b_n, 1'b1);
        tx_loc_n = 1'b1;
        rst_n = 1'b1;
        tick(1);
        // R1: idle after reset
        check("R1 drv_a_n idle", drv_a_n, 1'b1);
        check("R1 drv_b_n idle", drv_b_n, 1'b1);
        check("R1 rxd_n idle", rxd_n, 1'b1);
        check("R1 rxe_n idle", rxe_n, 1'b1);

        // Sweep of enables, transmit lines, far-node drive and thermal flag
        for (int k = 0; k < 128; k++) begin
            logic ea, eb, tl, te, xa, xb, th, ra, rb;
            ea = ~k[0]; eb = ~k[1]; tl = ~k[2]; te = ~k[3];
            xa = ~k[4]; xb = ~k[5]; th = k[6];
            en_a_n = k[0]; en_b_n = k[1]; tx_loc_n = k[2]; tx_exp_n = k[3];
            ext_a_n = k[4]; ext_b_n = k[5]; therm_sd = k[6];
            #1;
            ra = ea & xa;
            rb = eb & xb;
            // R3 R4 R5 R9: receive lines follow sources in the same cycle
            check("R3 R4 R5 R9 rxd_n", rxd_n, ~(tl | te | ra | rb));
            check("R3 R4 R5 R9 rxe_n", rxe_n, ~(tl | ra | rb));
            tick(1);
            // R2 R3 R5 R9: drive requests one edge later
            check("R2 R3 R5 R9 drv_a_n", drv_a_n, ~(ea & ~th & (tl | te | rb)));
            check("R2 R3 R5 R9 drv_b_n", drv_b_n, ~(eb & ~th & (tl | te | ra)));
            idle();
        end

        // R7: local transmit stuck dominant
        tx_loc_n = 1'b0;
        tick(TO - 1);
        check("R7 rxd_n before limit", rxd_n, 1'b0);
        tick(1);
        check("R7 rxd_n cut at limit", rxd_n, 1'b1);
        check("R7 rxe_n cut at limit", rxe_n, 1'b1);
        tick(10);
        check("R7 rxd_n stays cut", rxd_n, 1'b1);
        check("R7 drv_a_n released", drv_a_n, 1'b1);
        check("R7 drv_b_n released", drv_b_n, 1'b1);
        // R8: one recessive edge re-arms
        tx_loc_n = 1'b1;
        tick(1);
        tx_loc_n = 1'b0;
        #1;
        check("R8 rxd_n after re-arm", rxd_n, 1'b0);
        tick(1);
        check("R8 drv_a_n after re-arm", drv_a_n, 1'b0);
        idle();

        // R6: far node takes bus A as this unit releases it
        tx_loc_n = 1'b0;
        tick(1);
        check("R6 drv_a_n driving", drv_a_n, 1'b0);
        tx_loc_n = 1'b1;
        ext_a_n = 1'b0;
        #1;
        check("R6 rxd_n masked while driving", rxd_n, 1'b1);
        tick(1);
        check("R6 drv_b_n not echoed", drv_b_n, 1'b1);
        check("R6 rxd_n masked edge 0", rxd_n, 1'b1);
        for (int i = 1; i < REL; i++) begin
            tick(1);
            check("R6 rxd_n still masked", rxd_n, 1'b1);
        end
        tick(1);
        check("R6 rxd_n unmasked after release", rxd_n, 1'b0);
        check("R6 rxe_n unmasked after release", rxe_n, 1'b0);
        tick(1);
        check("R3 drv_b_n from bus A", drv_b_n, 1'b0);
        check("R6 drv_a_n no latch", drv_a_n, 1'b1);
        tick(5);
        check("R6 drv_a_n no latch later", drv_a_n, 1'b1);
        idle();
        check("R6 drv_b_n released", drv_b_n, 1'b1);

        // R10: short to battery on bus A
        sbat_a = 1'b1;
        tx_loc_n = 1'b0;
        tick(DEB - 1);
        check("R10 drv_a_n before debounce", drv_a_n, 1'b0);
        tick(1);
        check("R10 drv_a_n cut", drv_a_n, 1'b1);
        check("R10 drv_b_n unaffected", drv_b_n, 1'b0);
        tx_loc_n = 1'b1;
        tick(REL + 3);
        ext_a_n = 1'b0;
        #1;
        check("R10 bus A receiver works", rxd_n, 1'b0);
        ext_a_n = 1'b1;
        tick(REL + 3);
        sbat_a = 1'b0;
        tx_loc_n = 1'b0;
        tick(1);
        check("R10 drv_a_n restored", drv_a_n, 1'b0);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule